// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This unit decides whether a cache-block maintenance request may go ahead. It handles three kinds of request: zero a block, write back a block (clean or flush), and discard a block (invalidate). Each request carries an operation code, the current privilege level, a virtualization flag, and the enable bits for the operation class from three configuration levels: machine, hypervisor and supervisor. It also carries the effective address and two permission flags that were computed elsewhere, one for loads and one for stores.

One cycle after a request is accepted, the unit returns a result code and the block-aligned base address. The result is one of four values: permitted, illegal-instruction trap, virtual-instruction trap, or store-class fault. When a zero request is permitted, a byte-store sequencer then writes a zero byte to every address of the block. It writes one byte per valid/ready handshake and pulses a completion flag after the last byte. No new request is taken while the sequencer is busy.

Top module: `cbo_perm_check`

## Requirements
- R1: The enable slot is chosen by the operation code. Slot 0 (bit 0) is used for zero (op 0). Slot 1 is shared by clean (op 1) and flush (op 2). Slot 2 is used for invalidate (op 3).
- R2: At any privilege other than M (encoding U=0, S=1, M=3), a clear machine enable bit gives result 2 (illegal instruction). This holds whatever the virtualization flag, the other enable bits and the permission flags are.
- R3: With virtualization on, privilege U or S, and the machine bit set, a clear hypervisor bit gives result 22 (virtual instruction).
- R4: With virtualization on, privilege U, and the machine and hypervisor bits set, a clear supervisor bit gives result 22.
- R5: With virtualization off, privilege U, and the machine bit set, a clear supervisor bit gives result 2. At privilege S without virtualization, and at privilege M, the hypervisor and supervisor bits have no effect.
- R6: When no configuration trap applies, a zero request gives result 0 if store_ok is set and result 15 (store fault) if it is not.
- R7: When no configuration trap applies, a clean, flush or invalidate request gives result 0 if load_ok or store_ok is set, and result 15 if both are clear.
- R8: rsp_valid is high for exactly the one cycle after each accepted request. In that cycle rsp_base equals req_addr with its low log2(BLOCK_BYTES) bits cleared.
- R9: After a zero request with result 0, wr_valid rises in the same cycle as rsp_valid. The sequencer then issues BLOCK_BYTES writes of data 0, at rsp_base+0 up to rsp_base+BLOCK_BYTES-1 in ascending order. Each write completes on a cycle with wr_valid and wr_ready both high. While wr_ready is low, wr_valid and wr_addr hold.
- R10: zero_done is high for one cycle, the cycle after the last write handshake. req_ready is low whenever wr_valid is high.
- R11: A request whose result is not 0 issues no byte write.
- R12: During and right after reset, rsp_valid, wr_valid and zero_done are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (sequencer idle) |
| req_op | input | 2 | 0 zero, 1 clean, 2 flush, 3 invalidate |
| req_priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| req_virt | input | 1 | Virtualization active |
| m_en | input | 3 | Machine-level enable bits, one per slot |
| h_en | input | 3 | Hypervisor-level enable bits |
| s_en | input | 3 | Supervisor-level enable bits |
| req_addr | input | ADDR_W | Effective address |
| load_ok | input | 1 | Load access to the block is allowed |
| store_ok | input | 1 | Store access to the block is allowed |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_code | output | 5 | 0 ok, 2 illegal, 15 store fault, 22 virtual |
| rsp_base | output | ADDR_W | Block-aligned address |
| wr_valid | output | 1 | Byte write pending |
| wr_ready | input | 1 | Byte write taken |
| wr_addr | output | ADDR_W | Byte address |
| wr_data | output | 8 | Byte data (always zero) |
| zero_done | output | 1 | Block fully zeroed (one cycle) |

## Verification
The hardest corner to reach from the ports is a lower-priority rule being overridden by a higher one. Examples are a clear machine bit hiding clear hypervisor and supervisor bits, and virtualization turning a supervisor-bit miss into result 22 instead of 2. Random enable bits are biased toward set, so each rule fires alone with useful frequency. Directed requests also clear all three levels together to check that priority. The zero sequencer is driven with a stalling wr_ready so that held addresses and the final handshake are both observed.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

  typedef enum logic [1:0] {
    CBO_ZERO  = 2'd0,
    CBO_CLEAN = 2'd1,
    CBO_FLUSH = 2'd2,
    CBO_INVAL = 2'd3
  } cbo_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int RES_W = 5;
  localparam logic [RES_W-1:0] RES_OK      = 5'd0;
  localparam logic [RES_W-1:0] RES_ILLEGAL = 5'd2;
  localparam logic [RES_W-1:0] RES_SFAULT  = 5'd15;
  localparam logic [RES_W-1:0] RES_VIRT    = 5'd22;

  localparam int SLOTS = 3;

  // Which enable slot governs an operation class.
  function automatic logic [1:0] enable_slot(cbo_op_e op);
    case (op)
      CBO_ZERO:  return 2'd0;
      CBO_INVAL: return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

  // Access rule once configuration checks have passed.
  function automatic logic access_granted(cbo_op_e op, logic ld, logic st);
    if (op == CBO_ZERO) return st;
    return ld | st;
  endfunction

endpackage

// File: rtl/cbo_perm_decide.sv
module cbo_perm_decide
  import cbo_perm_pkg::*;
(
  input  cbo_op_e                 op,
  input  logic [1:0]              priv,
  input  logic                    virt,
  input  logic [SLOTS-1:0]        m_en,
  input  logic [SLOTS-1:0]        h_en,
  input  logic [SLOTS-1:0]        s_en,
  input  logic                    load_ok,
  input  logic                    store_ok,
  output logic [RES_W-1:0]        code
);

  logic [1:0] slot;
  logic       m_bit, h_bit, s_bit;
  logic       below_m, at_u, s_or_lower;
  logic       m_block, v_block, s_block, acc_ok;

  assign slot       = enable_slot(op);
  assign m_bit      = m_en[slot];
  assign h_bit      = h_en[slot];
  assign s_bit      = s_en[slot];
  assign below_m    = (priv != PRIV_M);
  assign at_u       = (priv == PRIV_U);
  assign s_or_lower = (priv == PRIV_U) || (priv == PRIV_S);

  assign m_block = below_m & ~m_bit;
  assign v_block = virt & ((s_or_lower & ~h_bit) | (at_u & ~s_bit));
  assign s_block = ~virt & at_u & ~s_bit;
  assign acc_ok  = access_granted(op, load_ok, store_ok);

  always_comb begin
    if (m_block)      code = RES_ILLEGAL;
    else if (v_block) code = RES_VIRT;
    else if (s_block) code = RES_ILLEGAL;
    else if (!acc_ok) code = RES_SFAULT;
    else              code = RES_OK;
  end

endmodule

// File: rtl/cbo_zero_seq.sv
module cbo_zero_seq #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BLOCK_BYTES - 1);

  logic [OFF_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              busy_q, done_q;
  logic              fire, last_fire;

  assign fire      = busy_q & wr_ready;
  assign last_fire = fire & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      done_q <= last_fire;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        base_q <= base;
      end else if (fire) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_fire) busy_q <= 1'b0;
      end
    end
  end

  assign wr_valid = busy_q;
  assign wr_addr  = base_q | ADDR_W'(cnt_q);
  assign wr_data  = 8'h00;
  assign busy     = busy_q;
  assign done     = done_q;

endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
  import cbo_perm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic [2:0]        m_en,
  input  logic [2:0]        h_en,
  input  logic [2:0]        s_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              load_ok,
  input  logic              store_ok,
  output logic              rsp_valid,
  output logic [4:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_base,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              zero_done
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_BYTES - 1);

  cbo_op_e           op;
  logic [RES_W-1:0]  code_now;
  logic [ADDR_W-1:0] base_now;
  logic              accept, seq_start, seq_busy;
  logic              rsp_valid_q;
  logic [RES_W-1:0]  rsp_code_q;
  logic [ADDR_W-1:0] rsp_base_q;

  assign op        = cbo_op_e'(req_op);
  assign base_now  = req_addr & ALIGN_MASK;
  assign req_ready = ~seq_busy;
  assign accept    = req_valid & req_ready;
  assign seq_start = accept & (op == CBO_ZERO) & (code_now == RES_OK);

  cbo_perm_decide u_decide (
    .op       (op),
    .priv     (req_priv),
    .virt     (req_virt),
    .m_en     (m_en),
    .h_en     (h_en),
    .s_en     (s_en),
    .load_ok  (load_ok),
    .store_ok (store_ok),
    .code     (code_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RES_OK;
      rsp_base_q  <= '0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) begin
        rsp_code_q <= code_now;
        rsp_base_q <= base_now;
      end
    end
  end

  cbo_zero_seq #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .base     (base_now),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (seq_busy),
    .done     (zero_done)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_base  = rsp_base_q;

  if (OFF_W < 1) begin : g_bad_block
    initial $error("BLOCK_BYTES must be at least 2");
  end

endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              req_ready,
  input logic [1:0]        req_priv,
  input logic [2:0]        m_en,
  input logic              rsp_valid,
  input logic [4:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_base,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              zero_done
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R8
  AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept)); // R8
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_base[OFF_W-1:0] == '0); // R8
  AST_M_CLEAR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_priv != 2'd3 && m_en == 3'b000) |=> rsp_code == 5'd2); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr))); // R9
  AST_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data == 8'h00); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !req_ready); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> !zero_done); // R10
  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 5'd0) |-> !wr_valid); // R11
endmodule

bind cbo_perm_check cbo_perm_check_sva #(
  .ADDR_W      (ADDR_W),
  .BLOCK_BYTES (BLOCK_BYTES)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .req_ready (req_ready),
  .req_priv  (req_priv),
  .m_en      (m_en),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .rsp_base  (rsp_base),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .zero_done (zero_done)
);

// File: tb/tb_cbo_perm_check.sv
module tb_cbo_perm_check;
  localparam int AW  = 32;
  localparam int BLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0, req_priv = '0;
  logic req_virt = 1'b0;
  logic [2:0] m_en = '0, h_en = '0, s_en = '0;
  logic [AW-1:0] req_addr = '0;
  logic load_ok = 1'b0, store_ok = 1'b0;
  logic rsp_valid;
  logic [4:0] rsp_code;
  logic [AW-1:0] rsp_base;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic zero_done;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cbo_perm_check #(.ADDR_W(AW), .BLOCK_BYTES(BLK)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_priv(req_priv), .req_virt(req_virt),
    .m_en(m_en), .h_en(h_en), .s_en(s_en), .req_addr(req_addr),
    .load_ok(load_ok), .store_ok(store_ok), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_base(rsp_base), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .zero_done(zero_done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected result, written as a priority ladder over privilege cases.
  function automatic int exp_code(int op, int pv, bit vt, bit [2:0] m, bit [2:0] h,
                                  bit [2:0] s, bit ld, bit st);
    int k;
    k = (op == 0) ? 0 : ((op == 3) ? 2 : 1);
    case (pv)
      3: ;
      1: begin
        if (!m[k]) return 2;
        if (vt && !h[k]) return 22;
      end
      default: begin
        if (!m[k]) return 2;
        if (vt && (!h[k] || !s[k])) return 22;
        if (!vt && !s[k]) return 2;
      end
    endcase
    if (op == 0) return st ? 0 : 15;
    return (ld || st) ? 0 : 15;
  endfunction

  // Issue one request, check the response, then drain any zeroing run.
  task automatic run_req(input int op, input int pv, input bit vt,
                         input bit [2:0] m, input bit [2:0] h, input bit [2:0] s,
                         input bit [AW-1:0] a, input bit ld, input bit st,
                         input int stall_pct, input string tag);
    int ec;
    bit [AW-1:0] eb;
    int idx;
    int guard;
    ec = exp_code(op, pv, vt, m, h, s, ld, st);
    eb = a & ~AW'(BLK - 1);
    @(negedge clk);
    req_op = 2'(op); req_priv = 2'(pv); req_virt = vt;
    m_en = m; h_en = h; s_en = s; req_addr = a; load_ok = ld; store_ok = st;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 rsp_valid"}, rsp_valid, 1);
    chk({tag, " result"}, rsp_code, ec);
    chk({tag, " R8 rsp_base"}, rsp_base, eb);
    if (op == 0 && ec == 0) begin
      chk("R9 wr_valid with rsp", wr_valid, 1);
      chk("R10 req_ready low while busy", req_ready, 0);
      idx = 0;
      guard = 0;
      while (idx < BLK && guard < 20 * BLK) begin
        bit r;
        guard++;
        if (wr_valid !== 1'b1 || wr_addr !== eb + AW'(idx)) begin
          chk("R9 write addr", wr_addr, eb + AW'(idx));
          chk("R9 write valid", wr_valid, 1);
        end
        if (wr_data !== 8'h00) chk("R9 write data", wr_data, 0);
        if (zero_done) chk("R10 early done", zero_done, 0);
        r = (($urandom % 100) >= stall_pct);
        wr_ready = r;
        @(posedge clk);
        @(negedge clk);
        if (r) idx++;
      end
      wr_ready = 1'b0;
      chk("R9 all bytes written", idx, BLK);
      chk("R10 zero_done pulse", zero_done, 1);
      chk("R10 wr_valid dropped", wr_valid, 0);
      @(negedge clk);
      chk("R10 zero_done one cycle", zero_done, 0);
    end else begin
      chk({tag, " R11 no write"}, wr_valid, 0);
      @(negedge clk);
      chk({tag, " R11 no write later"}, wr_valid, 0);
      chk({tag, " R8 single rsp"}, rsp_valid, 0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset rsp_valid", rsp_valid, 0);
    chk("R12 reset wr_valid", wr_valid, 0);
    chk("R12 reset zero_done", zero_done, 0);
    chk("R12 reset req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after reset req_ready", req_ready, 1);

    // Directed corners
    run_req(0, 0, 1, 3'b110, 3'b000, 3'b000, 32'h1234_5678, 1, 1, 0, "R2 m clear beats all");
    run_req(3, 1, 0, 3'b011, 3'b111, 3'b111, 32'h0000_0040, 1, 1, 0, "R2 inval slot2 clear");
    run_req(1, 1, 1, 3'b111, 3'b101, 3'b111, 32'h0000_1000, 1, 1, 0, "R3 virt S h clear");
    run_req(2, 0, 1, 3'b111, 3'b111, 3'b101, 32'h0000_2000, 1, 1, 0, "R4 virt U s clear");
    run_req(1, 0, 0, 3'b111, 3'b111, 3'b101, 32'h0000_3000, 1, 1, 0, "R5 U s clear");
    run_req(1, 1, 0, 3'b111, 3'b000, 3'b000, 32'h0000_3004, 1, 0, 0, "R5 S ignores h s");
    run_req(0, 3, 0, 3'b000, 3'b000, 3'b000, 32'hFFFF_FFFF, 0, 1, 0, "R5 M ignores cfg");
    run_req(0, 1, 0, 3'b001, 3'b000, 3'b000, 32'h0000_5000, 1, 0, 0, "R6 zero no store");
    run_req(3, 0, 0, 3'b100, 3'b000, 3'b100, 32'h0000_6000, 0, 1, 0, "R7 inval store only");
    run_req(2, 3, 0, 3'b000, 3'b000, 3'b000, 32'h0000_7000, 0, 0, 0, "R7 flush no access");
    run_req(1, 0, 1, 3'b010, 3'b010, 3'b010, 32'h0000_8000, 1, 0, 0, "R1 slot1 only");
    run_req(0, 0, 1, 3'b001, 3'b001, 3'b001, 32'h0000_9ABC, 0, 1, 0, "R1 zero slot0");
    run_req(0, 1, 0, 3'b001, 3'b000, 3'b000, 32'hABCD_EF3F, 0, 1, 60, "R9 stalled zero");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op, pv;
      bit vt, ld, st;
      bit [2:0] m, h, s;
      op = int'($urandom % 4);
      case ($urandom % 3) 0: pv = 0; 1: pv = 1; default: pv = 3; endcase
      vt = (pv != 3) && ($urandom % 2 == 1);
      for (int b = 0; b < 3; b++) begin
        m[b] = ($urandom % 5) != 0;
        h[b] = ($urandom % 5) != 0;
        s[b] = ($urandom % 5) != 0;
      end
      ld = ($urandom % 3) != 0;
      st = ($urandom % 3) != 0;
      run_req(op, pv, vt, m, h, s, $urandom, ld, st, int'($urandom % 50), "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule